// File: doc/BRIEF.md
# Serial GPIO Shift Master

This block drives a chain of external shift registers over three wires: a serial clock, a low-active load strobe, and a pair of data lines, one outbound and one inbound. Each frame begins with the load strobe held low for one serial clock period so that the far end can capture its parallel inputs. The master then moves one bit per serial clock in each direction for every line in use. The number of lines is set in whole bytes, so each frame carries eight lines per byte.

Software reaches the block through a small word-addressed register bus. A control word sets the serial clock divider, the byte count and the run enable. Lines are grouped into 32-bit banks. For each bank, one address is written to set the output lines and read to obtain the input lines captured in the last complete frame. A second address per bank reads back the outbound latch as it was last written. The serial clock period is the system clock period times 2 × (divider + 1), so the refresh rate of every line follows from the divider and the byte count.

Top module: `sgm_master`

## Requirements
- R1: Control word (address 0) reads back as: bits 31:16 hold the stored divider shifted left by one bit (truncated to 16 bits), bits 9:6 hold the stored byte count, bit 0 holds the enable, and all other bits read 0.
- R2: A divider of 0 written to bits 31:16 is stored as 1. Any value from 1 to 65535 is stored as written.
- R3: A byte count written to bits 9:6 is stored as 1 if it is 0, as MAX_BYTES (10) if it is larger, and as written otherwise.
- R4: While enabled, the serial clock stays high for divider+1 system cycles and low for divider+1 system cycles, giving a period of 2 × (divider + 1) cycles.
- R5: Each frame opens with the load strobe low for exactly one serial clock period. Exactly bytes×8 rising serial clock edges follow with the load strobe high, and the next frame's load strobe falls on the falling edge that ends the last bit. Frames repeat back to back while enabled.
- R6: The outbound data changes on falling serial clock edges. At the k-th shift rising edge of a frame (k from 0), it carries outbound line k, where line n is bit n&31 of bank n>>5. The values used are those in the latch when the frame's load strobe fell.
- R7: The inbound bit sampled at the k-th shift rising edge becomes line k. All captured lines are moved into the value registers together, at the edge that ends the frame. Lines at or above bytes×8 then read 0, and the value registers do not change at any other time.
- R8: Writing address 1+b sets the outbound latch of bank b. Reading address 1+b returns captured inputs. Reading address 1+BANKS+b (BANKS = 3) returns the latch. Latch bits of lines at or above MAX_BYTES×8 are not stored and read 0.
- R9: With enable low, the serial clock is held low, the load strobe high and the outbound data low. A frame in progress is abandoned, and the value registers keep their contents.
- R10: After reset the control word reads 0x00020040 (divider 1, one byte, disabled), every bank reads 0, the serial clock is low and the load strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, sampled on the rising clock edge |
| bus_addr | input | AW (3) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sgp_clk | output | 1 | Serial clock |
| sgp_load_n | output | 1 | Load strobe, active low |
| sgp_dout | output | 1 | Outbound serial data |
| sgp_din | input | 1 | Inbound serial data |

## Verification
On every cycle, the bound checker enforces several rules. The serial clock moves only on a divider tick while enabled, and the pins are idle whenever enable is low. A frame end is always followed by a falling load strobe. The captured-input registers change only at a frame end, and the stored divider and byte count never leave their legal ranges. Other behaviour shows only in whole frames, and the bench checks it while it sweeps byte counts and dividers, including the clamped values, against an external shift-chain model. This covers the exact half-period and load-pulse widths, the number of shifted bits, line ordering in both directions, the masking of unused lines, retention across a disable, and the delay of capture until the frame completes.

// File: rtl/sgm_pkg.sv
`timescale 1ns/1ps
package sgm_pkg;

  localparam int DIV_W   = 16;
  localparam int CNT_W   = 4;
  localparam int BANK_W  = 32;
  localparam int DIV_LSB = 16;
  localparam int CNT_LSB = 6;

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_SHIFT} phase_t;

  // Divider below one is not legal; it is raised to one.
  function automatic logic [DIV_W-1:0] fix_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  // Byte count limited to 1..max_bytes.
  function automatic logic [CNT_W-1:0] fix_bytes(input logic [CNT_W-1:0] b,
                                                 input int unsigned max_bytes);
    if (b == '0) return CNT_W'(1);
    if (32'(b) > max_bytes) return CNT_W'(max_bytes);
    return b;
  endfunction

  // Control word as seen on a read; divider comes back doubled.
  function automatic logic [31:0] ctrl_word(input logic [DIV_W-1:0] d,
                                            input logic [CNT_W-1:0] b,
                                            input logic en);
    return {d[DIV_W-2:0], 1'b0, 6'b0, b, 5'b0, en};
  endfunction

  function automatic int unsigned bank_count(input int unsigned max_bytes);
    return (max_bytes * 8 + BANK_W - 1) / BANK_W;
  endfunction

endpackage

// File: rtl/sgm_divider.sv
`timescale 1ns/1ps
module sgm_divider
  import sgm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] hcnt;

  // One tick per half serial period: divider+1 system cycles.
  assign tick = run && (hcnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
    end else if (!run || tick) begin
      hcnt <= '0;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

endmodule

// File: rtl/sgm_frame.sv
`timescale 1ns/1ps
module sgm_frame
  import sgm_pkg::*;
#(
  parameter int MAX_LINES = 80,
  parameter int LW        = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 tick,
  input  logic [LW-1:0]        lines,
  input  logic [MAX_LINES-1:0] out_vec,
  input  logic                 sin,
  output logic                 sclk,
  output logic                 load_n,
  output logic                 sout,
  output logic [MAX_LINES-1:0] cap_vec,
  output logic                 commit,
  output logic                 run
);

  phase_t               phase;
  logic [LW-1:0]        bit_idx;
  logic [LW-1:0]        nlines_q;
  logic [LW-1:0]        nxt_idx;
  logic [MAX_LINES-1:0] snap;
  logic                 last_bit;
  logic                 rise_evt;
  logic                 fall_evt;

  assign run      = (phase != PH_IDLE);
  assign rise_evt = en && tick && !sclk;
  assign fall_evt = en && tick && sclk;
  assign last_bit = (bit_idx == nlines_q - 1'b1);
  assign nxt_idx  = bit_idx + 1'b1;
  assign commit   = fall_evt && (phase == PH_SHIFT) && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      sclk     <= 1'b0;
      load_n   <= 1'b1;
      sout     <= 1'b0;
      bit_idx  <= '0;
      nlines_q <= '0;
      snap     <= '0;
      cap_vec  <= '0;
    end else if (!en) begin
      phase  <= PH_IDLE;
      sclk   <= 1'b0;
      load_n <= 1'b1;
      sout   <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phase    <= PH_LOAD;
          load_n   <= 1'b0;
          sclk     <= 1'b0;
          snap     <= out_vec;
          nlines_q <= lines;
          cap_vec  <= '0;
        end
        PH_LOAD: begin
          if (tick) sclk <= ~sclk;
          if (fall_evt) begin
            phase   <= PH_SHIFT;
            load_n  <= 1'b1;
            bit_idx <= '0;
            sout    <= snap[0];
          end
        end
        PH_SHIFT: begin
          if (tick) sclk <= ~sclk;
          if (rise_evt) begin
            cap_vec[bit_idx] <= sin;
          end else if (fall_evt) begin
            if (last_bit) begin
              phase    <= PH_LOAD;
              load_n   <= 1'b0;
              sout     <= 1'b0;
              snap     <= out_vec;
              nlines_q <= lines;
              cap_vec  <= '0;
            end else begin
              bit_idx <= nxt_idx;
              sout    <= snap[nxt_idx];
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sgm_regs.sv
`timescale 1ns/1ps
module sgm_regs
  import sgm_pkg::*;
#(
  parameter int MAX_BYTES = 10,
  parameter int BANKS     = 3,
  parameter int AW        = 3,
  parameter int LW        = 7,
  parameter int MAX_LINES = 80,
  localparam int BANK_BITS = BANKS * BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 commit,
  input  logic [MAX_LINES-1:0] cap_vec,
  output logic                 ctrl_en,
  output logic [DIV_W-1:0]     div_val,
  output logic [CNT_W-1:0]     byte_val,
  output logic [LW-1:0]        lines,
  output logic [MAX_LINES-1:0] out_vec,
  output logic [BANK_BITS-1:0] in_val_vec
);

  logic [BANK_BITS-1:0] latch_vec;
  logic [BANK_BITS-1:0] vmask;
  logic [BANK_BITS-1:0] lmask;
  logic [BANK_BITS-1:0] cap_ext;
  logic                 ctrl_hit;

  assign lines    = LW'({byte_val, 3'b000});
  assign out_vec  = latch_vec[MAX_LINES-1:0];
  assign ctrl_hit = bus_we && (bus_addr == '0);

  always_comb begin
    cap_ext = '0;
    cap_ext[MAX_LINES-1:0] = cap_vec;
    for (int i = 0; i < BANK_BITS; i++) begin
      vmask[i] = (i < MAX_LINES);
      lmask[i] = (i < int'(lines));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_val  <= DIV_W'(1);
      byte_val <= CNT_W'(1);
      ctrl_en  <= 1'b0;
    end else if (ctrl_hit) begin
      div_val  <= fix_div(bus_wdata[DIV_LSB +: DIV_W]);
      byte_val <= fix_bytes(bus_wdata[CNT_LSB +: CNT_W], MAX_BYTES);
      ctrl_en  <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_val_vec <= '0;
    end else if (commit) begin
      in_val_vec <= cap_ext & lmask;
    end
  end

  logic [31:0] val_word [BANKS];
  logic [31:0] rb_word  [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic bank_hit;
    assign bank_hit    = bus_we && (bus_addr == AW'(1 + b));
    assign val_word[b] = in_val_vec[b*BANK_W +: BANK_W];
    assign rb_word[b]  = latch_vec[b*BANK_W +: BANK_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latch_vec[b*BANK_W +: BANK_W] <= '0;
      end else if (bank_hit) begin
        latch_vec[b*BANK_W +: BANK_W] <= bus_wdata & vmask[b*BANK_W +: BANK_W];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) bus_rdata = ctrl_word(div_val, byte_val, ctrl_en);
    for (int b = 0; b < BANKS; b++) begin
      if (bus_addr == AW'(1 + b))         bus_rdata = val_word[b];
      if (bus_addr == AW'(1 + BANKS + b)) bus_rdata = rb_word[b];
    end
  end

endmodule

// File: rtl/sgm_master.sv
`timescale 1ns/1ps
module sgm_master
  import sgm_pkg::*;
#(
  parameter int  MAX_BYTES = 10,
  localparam int BANKS     = bank_count(MAX_BYTES),
  localparam int AW        = $clog2(2 * BANKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          sgp_clk,
  output logic          sgp_load_n,
  output logic          sgp_dout,
  input  logic          sgp_din
);

  localparam int MAX_LINES = MAX_BYTES * 8;
  localparam int LW        = $clog2(MAX_LINES + 1);
  localparam int BANK_BITS = BANKS * BANK_W;

  logic                 ctrl_en;
  logic [DIV_W-1:0]     div_val;
  logic [CNT_W-1:0]     byte_val;
  logic [LW-1:0]        line_cnt;
  logic [MAX_LINES-1:0] out_vec;
  logic [MAX_LINES-1:0] cap_vec;
  logic [BANK_BITS-1:0] in_val_vec;
  logic                 half_tick;
  logic                 frame_run;
  logic                 frame_commit;

  sgm_regs #(
    .MAX_BYTES (MAX_BYTES),
    .BANKS     (BANKS),
    .AW        (AW),
    .LW        (LW),
    .MAX_LINES (MAX_LINES)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .commit     (frame_commit),
    .cap_vec    (cap_vec),
    .ctrl_en    (ctrl_en),
    .div_val    (div_val),
    .byte_val   (byte_val),
    .lines      (line_cnt),
    .out_vec    (out_vec),
    .in_val_vec (in_val_vec)
  );

  sgm_divider u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (frame_run),
    .div   (div_val),
    .tick  (half_tick)
  );

  sgm_frame #(
    .MAX_LINES (MAX_LINES),
    .LW        (LW)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_en),
    .tick    (half_tick),
    .lines   (line_cnt),
    .out_vec (out_vec),
    .sin     (sgp_din),
    .sclk    (sgp_clk),
    .load_n  (sgp_load_n),
    .sout    (sgp_dout),
    .cap_vec (cap_vec),
    .commit  (frame_commit),
    .run     (frame_run)
  );

endmodule

// File: rtl/sgm_master_chk.sv
`timescale 1ns/1ps
module sgm_master_chk
  import sgm_pkg::*;
#(
  parameter int  MAX_BYTES = 10,
  localparam int VW        = bank_count(MAX_BYTES) * BANK_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             tick,
  input logic             sclk,
  input logic             load_n,
  input logic             commit,
  input logic [VW-1:0]    in_val,
  input logic [DIV_W-1:0] div,
  input logic [CNT_W-1:0] bytes
);

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sclk && load_n)); // R9

  AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(sclk)); // R4

  AST_COMMIT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !load_n); // R5

  AST_VAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(in_val)); // R7

  AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    div != '0); // R2

  AST_BYTES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (bytes != '0) && (32'(bytes) <= MAX_BYTES)); // R3

endmodule

bind sgm_master sgm_master_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (ctrl_en),
  .tick   (half_tick),
  .sclk   (sgp_clk),
  .load_n (sgp_load_n),
  .commit (frame_commit),
  .in_val (in_val_vec),
  .div    (div_val),
  .bytes  (byte_val)
);

// File: tb/sgm_master_tb.sv
`timescale 1ns/1ps
module sgm_master_tb;

  localparam int NB    = 10;
  localparam int LINES = NB * 8;
  localparam int BK    = 3;
  localparam int TCK   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sgp_clk, sgp_load_n, sgp_dout, sgp_din;

  int nvec = 0;
  int nerr = 0;

  logic [LINES-1:0] pin_pat = '0;
  logic [LINES-1:0] shreg = '0;
  logic [LINES-1:0] rx_vec = '0;
  int               rx_cnt = 0;
  logic [95:0]      exp_val = '0;
  logic [95:0]      out_pat = '0;

  always #(TCK/2) clk = ~clk;

  sgm_master #(.MAX_BYTES(NB)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .sgp_clk    (sgp_clk),
    .sgp_load_n (sgp_load_n),
    .sgp_dout   (sgp_dout),
    .sgp_din    (sgp_din)
  );

  // External shift chain: parallel load while strobe low, shift on rising edges.
  assign sgp_din = shreg[0];
  always @(posedge sgp_clk) begin
    if (!sgp_load_n) begin
      shreg  <= pin_pat;
      rx_cnt <= 0;
    end else begin
      if (rx_cnt < LINES) rx_vec[rx_cnt] <= sgp_dout;
      rx_cnt <= rx_cnt + 1;
      shreg  <= shreg >> 1;
    end
  end

  function automatic logic pbit(input int i, input int s);
    return ((i * 5 + s * 11 + i * i) % 7) < 3;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 3'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic run_frame(input int bw, input int dw, input int seed);
    int eb, ed, n, mism;
    logic [31:0] d, raw;
    longint t0, t1, ta, tm, tb;
    eb = (bw == 0) ? 1 : ((bw > NB) ? NB : bw);
    ed = (dw == 0) ? 1 : dw;
    n  = eb * 8;
    wr(0, (32'(dw) << 16) | (32'(bw) << 6));
    rd(0, d);
    chk((bw != eb) ? "R3 byte clamp" : ((dw != ed) ? "R2 divider clamp" : "R1 ctrl readback"),
        d, ((((ed * 2) % 65536)) << 16) | (eb << 6));
    for (int b = 0; b < BK; b++) begin
      for (int j = 0; j < 32; j++) begin
        raw[j] = pbit(b * 32 + j, seed + 1);
        out_pat[b*32+j] = (b * 32 + j < LINES) ? raw[j] : 1'b0;
      end
      wr(1 + b, raw);
    end
    for (int b = 0; b < BK; b++) begin
      rd(1 + BK + b, d);
      chk("R8 latch readback", d, out_pat[b*32 +: 32]);
      rd(1 + b, d);
      chk("R9 values kept while disabled", d, exp_val[b*32 +: 32]);
    end
    for (int i = 0; i < LINES; i++) pin_pat[i] = pbit(i, seed);
    wr(0, (32'(dw) << 16) | (32'(bw) << 6) | 32'd1);
    @(negedge sgp_load_n); t0 = $time;
    @(posedge sgp_load_n); t1 = $time;
    chk("R5 load width", (t1 - t0) / TCK, 2 * (ed + 1));
    rd(1, d);
    chk("R7 no update before frame end", d, exp_val[31:0]);
    @(posedge sgp_clk); ta = $time;
    @(negedge sgp_clk); tm = $time;
    @(posedge sgp_clk); tb = $time;
    chk("R4 high half", (tm - ta) / TCK, ed + 1);
    chk("R4 period", (tb - ta) / TCK, 2 * (ed + 1));
    @(negedge sgp_load_n);
    chk("R5 shift count", rx_cnt, n);
    mism = 0;
    for (int i = 0; i < n; i++) if (rx_vec[i] !== out_pat[i]) mism++;
    chk("R6 outbound order", mism, 0);
    for (int i = 0; i < 96; i++) exp_val[i] = (i < n) ? pin_pat[i] : 1'b0;
    repeat (2) @(negedge clk);
    for (int b = 0; b < BK; b++) begin
      rd(1 + b, d);
      chk("R7 captured inputs", d, exp_val[b*32 +: 32]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int bad;
    repeat (3) @(negedge clk);
    chk("R10 reset sclk", sgp_clk, 0);
    chk("R10 reset load", sgp_load_n, 1);
    chk("R10 reset dout", sgp_dout, 0);
    rst_n = 1'b1;
    rd(0, d);
    chk("R10 reset ctrl", d, 32'h0002_0040);
    for (int a = 1; a <= 2 * BK; a++) begin
      rd(a, d);
      chk("R10 reset bank", d, 0);
    end
    run_frame(1, 1, 1);
    run_frame(2, 2, 2);
    run_frame(3, 1, 3);
    run_frame(0, 0, 4);
    run_frame(15, 2, 5);
    run_frame(5, 4, 6);
    run_frame(10, 3, 7);
    run_frame(7, 65535 % 5 + 1, 8);
    run_frame(10, 1, 9);
    // Bits past the last line are not stored.
    wr(3, 32'hFFFF_FFFF);
    rd(3 + BK, d);
    chk("R8 unused lines masked", d, 32'h0000_FFFF);
    // Abandon a frame mid-way.
    repeat (50) @(negedge clk);
    wr(0, (32'd1 << 16) | (32'd10 << 6));
    bad = 0;
    repeat (300) begin
      @(negedge clk);
      if (sgp_clk !== 1'b0 || sgp_load_n !== 1'b1 || sgp_dout !== 1'b0) bad++;
    end
    chk("R9 pins idle when disabled", bad, 0);
    for (int b = 0; b < BK; b++) begin
      rd(1 + b, d);
      chk("R9 values retained", d, exp_val[b*32 +: 32]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule